// File: doc/BRIEF.md
# Synchronous Reset Response Serializer

This block produces a fixed answer-to-reset bit stream for a memory-card style serial device. A host raises a dedicated reset pin and, while that pin is high, gives one pulse on the serial clock. When the reset pin falls, the block drives the first bit of a constant 32-bit pattern on the serial data line. Each following falling edge of the serial clock presents the next bit. After the last bit it releases the line and goes back to standby.

The block ignores a trigger while the device's nonvolatile write is busy, and it drops to standby at once when power-good falls. A second reset pulse during the response restarts the pattern from bit 0 if a clock rising edge falls inside the pulse. Without that clock edge, the same pulse aborts the response.

All four inputs are sampled on a fast system clock through a synchronizer of configurable depth. The pin-level serial clock is treated as an oversampled signal, not as a clock domain. The output pair is a data bit and an output enable for the open-drain pad.

Top module: `atr_serializer`

## Requirements
- R1: After system reset, and whenever the block is in standby, `sdo_oe_o` is 0 and `sdo_o` is 1 (line released).
- R2: A response starts when the reset pin falls, if a serial-clock rising edge was seen while the reset pin was high. The rising edge may arrive in the same sample as the reset pin's rise. On start, `sdo_oe_o` becomes 1 and bit 0 is driven.
- R3: While active and with the reset pin low, each serial-clock falling edge advances one bit. Bit k of the stream is bit k of the word 32'h55AA0219. Byte 19h goes first, then 02h, AAh and 55h, each byte least significant bit first. A serial-clock falling edge while the reset pin is high does not advance the stream.
- R4: The falling edge that follows bit 31 returns the block to standby.
- R5: If the write-busy input is high when the reset pin falls, no response starts and the block is in standby.
- R6: A reset pulse containing a serial-clock rising edge during an active response restarts the stream at bit 0. The current bit is held while the pulse lasts.
- R7: A reset pulse with no serial-clock rising edge inside it, during an active response, aborts to standby. Later serial clocks produce no output.
- R8: Power-good low forces standby and discards any clock edge already seen inside the current reset pulse. If power returns before the reset pin falls, no response starts.
- R9: In standby, a reset pulse with no clock edge inside it, and serial clocks with the reset pin low, leave the line released.
- R10: Each input passes through SYNC_STAGES flops. An input change is reflected at the outputs after SYNC_STAGES+1 rising system-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the pin inputs |
| rst_n | input | 1 | Active-low asynchronous system reset |
| atr_trig_i | input | 1 | Reset pin that triggers the response |
| ser_clk_i | input | 1 | Serial clock pin |
| nvw_busy_i | input | 1 | High while a nonvolatile write cycle runs |
| pwr_ok_i | input | 1 | Power-good indication, low aborts |
| sdo_o | output | 1 | Serial data bit, 1 when released |
| sdo_oe_o | output | 1 | Pad drive enable for the open-drain line |

## Verification
The hardest state to reach is a reset pulse landing in the middle of a running response. Its effect depends on whether a clock rising edge falls inside the pulse. The clock falling edge inside that pulse must also not advance the bit index. The stimulus first starts a response and clocks it partway. It then issues both kinds of pulse, and separately drops power-good inside a pulse that already saw its clock edge. A behavioural model predicts every cycle, including the synchronizer delay, so a held or skipped bit shows up at once.

// File: rtl/atr_pkg.sv
package atr_pkg;

   localparam logic [31:0] ATR_DEFAULT_WORD = 32'h55AA_0219;

   // synchronised pin levels
   typedef struct packed {
      logic pin_rst;
      logic sclk;
      logic wr_busy;
      logic pwr_ok;
   } atr_pins_t;

   // one-cycle control events from the trigger decoder
   typedef struct packed {
      logic kill;
      logic launch;
      logic stop;
      logic adv;
   } atr_evt_t;

endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("atr_sync: W must be at least 1");
      end
      if (STAGES < 0 || STAGES > 4) begin : g_bad_st
         $error("atr_sync: STAGES must lie in 0..4");
      end

      if (STAGES == 0) begin : g_bypass
         assign d_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg <= '0;
            end else begin
               stg[0] <= d_i;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign d_o = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/atr_trigger.sv
module atr_trigger
   import atr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  atr_pins_t pins,
   output atr_evt_t  evt
);

   logic prev_rst, prev_clk, armed;
   logic clk_rise, clk_fall, rst_fall, go_ok;

   assign clk_rise = pins.sclk & ~prev_clk;
   assign clk_fall = ~pins.sclk & prev_clk;
   assign rst_fall = ~pins.pin_rst & prev_rst;
   assign go_ok    = armed & ~pins.wr_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_rst <= 1'b0;
         prev_clk <= 1'b0;
      end else begin
         prev_rst <= pins.pin_rst;
         prev_clk <= pins.sclk;
      end
   end

   // a clock rising edge seen inside the reset pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        armed <= 1'b0;
      else if (!pins.pwr_ok || rst_fall) armed <= 1'b0;
      else if (pins.pin_rst && clk_rise) armed <= 1'b1;
   end

   always_comb begin
      evt.kill   = ~pins.pwr_ok;
      evt.launch = pins.pwr_ok & rst_fall & go_ok;
      evt.stop   = pins.pwr_ok & rst_fall & ~go_ok;
      evt.adv    = pins.pwr_ok & clk_fall & ~pins.pin_rst & ~prev_rst;
   end

   // R7: a pulse that ends without an armed, idle trigger never launches
   p_stop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_fall && !armed) |-> !evt.launch);

endmodule

// File: rtl/atr_bit_seq.sv
module atr_bit_seq
   import atr_pkg::*;
#(
   parameter int          RESP_BITS = 32,
   parameter logic [31:0] RESP_WORD = ATR_DEFAULT_WORD,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  atr_evt_t evt,
   output logic     active,
   output logic     bit_o
);

   localparam int             IDX_W = $clog2(RESP_BITS);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(RESP_BITS - 1);

   logic [IDX_W-1:0] idx, sel;

   generate
      if (RESP_BITS < 8 || RESP_BITS > 32 || (RESP_BITS % 8) != 0) begin : g_bad
         $error("atr_bit_seq: RESP_BITS must be 8, 16, 24 or 32");
      end
      if (LSB_FIRST) begin : g_lsb
         assign sel = idx;
      end else begin : g_msb
         assign sel = idx ^ IDX_W'(7);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (evt.kill || evt.stop) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (evt.launch) begin
         active <= 1'b1;
         idx    <= '0;
      end else if (evt.adv && active) begin
         if (idx == LAST) begin
            active <= 1'b0;
            idx    <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign bit_o = RESP_WORD[sel];

   // R2: launch always lands on bit 0
   p_launch_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.launch && !evt.kill) |=> (active && idx == '0));

   // R3: without an event the bit position is held
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !evt.adv && !evt.launch && !evt.stop && !evt.kill) |=> $stable(idx));

   // R4: the edge after the final bit ends the response
   p_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && idx == LAST && evt.adv && !evt.launch && !evt.stop && !evt.kill)
      |=> !active);

endmodule

// File: rtl/atr_serializer.sv
module atr_serializer
   import atr_pkg::*;
#(
   parameter int          RESP_BITS   = 32,
   parameter logic [31:0] RESP_WORD   = ATR_DEFAULT_WORD,
   parameter bit          LSB_FIRST   = 1'b1,
   parameter int          SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic atr_trig_i,
   input  logic ser_clk_i,
   input  logic nvw_busy_i,
   input  logic pwr_ok_i,
   output logic sdo_o,
   output logic sdo_oe_o
);

   localparam int PIN_W = $bits(atr_pins_t);

   logic [PIN_W-1:0] raw_pins, sync_pins;
   atr_pins_t        pins;
   atr_evt_t         evt;
   logic             active, cur_bit;

   assign raw_pins = {atr_trig_i, ser_clk_i, nvw_busy_i, pwr_ok_i};

   atr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_pins),
      .d_o   (sync_pins)
   );

   assign pins = atr_pins_t'(sync_pins);

   atr_trigger u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .pins  (pins),
      .evt   (evt)
   );

   atr_bit_seq #(
      .RESP_BITS (RESP_BITS),
      .RESP_WORD (RESP_WORD),
      .LSB_FIRST (LSB_FIRST)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt),
      .active (active),
      .bit_o  (cur_bit)
   );

   assign sdo_oe_o = active;
   assign sdo_o    = active ? cur_bit : 1'b1;

   // R1: a released line always reads high
   p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe_o |-> sdo_o);

   // R5: a response never begins while the write cycle is busy
   p_busy_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe_o) |-> $past(!pins.wr_busy));

   // R8: power-good low forces standby on the next edge
   p_pwr_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pins.pwr_ok |=> !sdo_oe_o);

endmodule

// File: tb/atr_serializer_test.sv
module atr_serializer_test;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int HALF       = 4;
   localparam int NBITS      = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig = 1'b0, sclk = 1'b0, busy = 1'b0, pg = 1'b1;
   logic sdo, sdo_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   atr_serializer #(.SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .atr_trig_i(trig), .ser_clk_i(sclk),
      .nvw_busy_i(busy), .pwr_ok_i(pg), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
   );

   // ---------------- behavioural reference ----------------
   logic [7:0] resp_bytes [4] = '{8'h19, 8'h02, 8'hAA, 8'h55};
   logic [3:0] hist [SYNC+1];          // {trig, sclk, busy, pg}, newest at 0
   bit m_active = 0, m_armed = 0;
   int m_idx = 0;

   function automatic logic stream_bit(int k);
      logic [7:0] b;
      b = resp_bytes[k / 8];
      return b[k % 8];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i <= SYNC; i++) hist[i] = 4'b0;
         m_active = 0; m_armed = 0; m_idx = 0;
      end else begin
         logic [3:0] c, p;
         c = hist[SYNC-1];
         p = hist[SYNC];
         if (!c[0]) begin
            m_active = 0; m_idx = 0; m_armed = 0;
         end else if (!c[3] && p[3]) begin
            m_active = m_armed && !c[1];
            m_idx = 0;
            m_armed = 0;
         end else begin
            if (c[3] && c[2] && !p[2]) m_armed = 1;
            if (!c[2] && p[2] && !c[3] && !p[3] && m_active) begin
               if (m_idx == NBITS-1) begin m_active = 0; m_idx = 0; end
               else m_idx++;
            end
         end
         for (int i = SYNC; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = {trig, sclk, busy, pg};
      end
   end

   task automatic check(string req, logic [1:0] act, logic [1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {oe,sdo} actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done)
         check(cur_req, {sdo_oe, sdo}, {m_active, m_active ? stream_bit(m_idx) : 1'b1});
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sclk_pulses(int n);
      repeat (n) begin
         sclk = 1'b1; tick(HALF);
         sclk = 1'b0; tick(HALF);
      end
   endtask

   task automatic rst_pulse(bit with_clk);
      trig = 1'b1; tick(HALF);
      if (with_clk) begin
         sclk = 1'b1; tick(HALF);
         sclk = 1'b0; tick(HALF);
      end
      trig = 1'b0; tick(HALF);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(6);
      cur_req = "R1";
      check("R1", {sdo_oe, sdo}, 2'b01);

      // R10: output follows the reset-pin fall after SYNC+1 edges
      cur_req = "R10";
      trig = 1'b1; tick(HALF);
      sclk = 1'b1; tick(HALF);
      sclk = 1'b0; tick(HALF);
      trig = 1'b0;
      for (int k = 1; k <= SYNC + 2; k++) begin
         @(negedge clk);
         check("R10", {sdo_oe, 1'b0}, {(k >= SYNC + 1) ? 1'b1 : 1'b0, 1'b0});
      end
      check("R2", {sdo_oe, sdo}, {1'b1, stream_bit(0)});

      // R3/R4: the whole stream, bit by bit
      cur_req = "R3";
      for (int k = 1; k < NBITS; k++) begin
         sclk_pulses(1);
         check("R3", {sdo_oe, sdo}, {1'b1, stream_bit(k)});
      end
      cur_req = "R4";
      sclk_pulses(1);
      check("R4", {sdo_oe, sdo}, 2'b01);
      sclk_pulses(2);
      check("R4", {sdo_oe, sdo}, 2'b01);

      // R5: busy blocks the start
      cur_req = "R5";
      busy = 1'b1;
      rst_pulse(1'b1);
      check("R5", {sdo_oe, sdo}, 2'b01);
      sclk_pulses(2);
      check("R5", {sdo_oe, sdo}, 2'b01);
      busy = 1'b0; tick(HALF);

      // R6: restart partway through
      cur_req = "R6";
      rst_pulse(1'b1);
      sclk_pulses(10);
      check("R6", {sdo_oe, sdo}, {1'b1, stream_bit(10)});
      rst_pulse(1'b1);
      check("R6", {sdo_oe, sdo}, {1'b1, stream_bit(0)});
      sclk_pulses(1);
      check("R6", {sdo_oe, sdo}, {1'b1, stream_bit(1)});
      sclk_pulses(NBITS - 1);
      check("R6", {sdo_oe, sdo}, 2'b01);

      // R7: pulse without clock aborts
      cur_req = "R7";
      rst_pulse(1'b1);
      sclk_pulses(5);
      check("R7", {sdo_oe, sdo}, {1'b1, stream_bit(5)});
      rst_pulse(1'b0);
      check("R7", {sdo_oe, sdo}, 2'b01);
      sclk_pulses(3);
      check("R7", {sdo_oe, sdo}, 2'b01);

      // R9: idle pulses and clocks do nothing
      cur_req = "R9";
      rst_pulse(1'b0);
      sclk_pulses(2);
      check("R9", {sdo_oe, sdo}, 2'b01);

      // R8: power loss aborts and forgets the armed edge
      cur_req = "R8";
      rst_pulse(1'b1);
      sclk_pulses(4);
      check("R8", {sdo_oe, sdo}, {1'b1, stream_bit(4)});
      pg = 1'b0; tick(HALF);
      check("R8", {sdo_oe, sdo}, 2'b01);
      pg = 1'b1; tick(HALF);
      sclk_pulses(2);
      check("R8", {sdo_oe, sdo}, 2'b01);
      trig = 1'b1; tick(HALF);
      sclk = 1'b1; tick(HALF);
      sclk = 1'b0; tick(HALF);
      pg = 1'b0; tick(HALF);
      pg = 1'b1; tick(HALF);
      trig = 1'b0; tick(HALF);
      check("R8", {sdo_oe, sdo}, 2'b01);

      // R2: same-sample rise of reset pin and clock still arms
      cur_req = "R2";
      trig = 1'b1; sclk = 1'b1; tick(HALF);
      sclk = 1'b0; tick(HALF);
      trig = 1'b0; tick(HALF);
      check("R2", {sdo_oe, sdo}, {1'b1, stream_bit(0)});
      sclk_pulses(NBITS);
      check("R4", {sdo_oe, sdo}, 2'b01);

      tick(4);
      finish_run();
   end

endmodule